// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a slave on a two-wire serial bus (a clock line and an open-drain data line). It gives a master access to four byte-wide registers that belong to the neighbouring thermostat logic. Both bus lines are oversampled by the system clock. The block detects START, repeated START and STOP, and shifts every byte MSB first. It acknowledges its own 7-bit address and the bytes it receives by pulling the data line low through a pull-low enable.

A write transaction carries a pointer byte right after the address byte, then zero or more data bytes. Every data byte is presented to the register file as a one-cycle write strobe aimed at the pointed register. A read transaction carries no pointer. It returns the register the pointer last selected, and keeps returning it for as long as the master acknowledges. The pointer survives STOP and later reads. It must be given again in each write. After reset it selects the temperature register.

The register-file port is stream-like only in one direction. `wr_valid_o` qualifies `wr_sel_o` and `wr_data_o` for exactly one cycle, and there is no ready. The bus clock cannot be held low, so there is no back-pressure: the receiver must take every strobe in the cycle it is raised. On reads, `rd_sel_o` names the register, and `rd_data_i` must reflect that register combinationally. It is captured at the clock-line fall that starts each byte.

Top module: `tw_ptr_slave`

## Requirements
- R1: A START (data falling while clock is high) or a repeated START begins a fresh address phase from any state, including mid-byte. A STOP (data rising while clock is high) returns the block to idle with the data line released.
- R2: The first byte after START is a 7-bit address followed by a direction bit (1 = read, 0 = write), MSB first. When the address equals `DEV_ADDR`, the block holds `sda_oe_o` high for the ninth clock period. It never drives the line while address bits are being shifted.
- R3: On an address mismatch, the block neither acknowledges nor drives the data line nor raises a write strobe until the next START or STOP.
- R4: In a write, the byte after the address is the pointer. Its two least significant bits select the register: 00 temperature, 01 configuration, 10 hysteresis threshold, 11 high trip threshold. Its upper six bits are ignored, and the byte is acknowledged.
- R5: Each further byte of a write is acknowledged and produces one `wr_valid_o` strobe, with `wr_sel_o` equal to the pointer and `wr_data_o` equal to the byte.
- R6: In a read, the block sends the pointed register MSB first, starting at the clock fall that ends the address acknowledge. It releases the data line during the master's acknowledge slot.
- R7: A master acknowledge makes the block send the same register again. A master NACK makes it stop driving the data line until the next START or STOP.
- R8: The pointer resets to 00 and keeps its value across STOP and across read transactions, so a read needs no pointer byte.
- R9: A write that ends after the address byte leaves the pointer unchanged. A pointer written just before a repeated START selects the register for the following read.
- R10: Both bus inputs pass through two-flop synchronizers. `sda_oe_o` only rises while the synchronized clock line is low.
- R11: `wr_valid_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull data line low when high |
| rd_sel_o | output | SEL_W | Register selected by the pointer |
| rd_data_i | input | 8 | Contents of the register named by `rd_sel_o` |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_sel_o | output | SEL_W | Register targeted by the strobe |
| wr_data_o | output | 8 | Byte to write |

## Verification
Two actions share a clock-line fall. At the fall that ends the eighth bit of a written byte, the write strobe and the acknowledge pull-low are raised in the same system cycle. At the fall that ends the pointer byte, the pointer load and the acknowledge coincide. The bench provokes both by sweeping every pointer value with multi-byte writes. It judges each byte by the acknowledge seen on the wire, by a strobe counter that must rise by exactly one per byte, and by a bench register model read back through the bus. A repeated START issued straight after a pointer write then confirms that the freshly loaded pointer, not the old one, feeds the read.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_PTR,
    S_PACK,
    S_WR,
    S_WACK,
    S_RD,
    S_RACK,
    S_IGN
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_lvl   = scl_s;
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_ptr_reg.sv
module tw_ptr_reg #(
  parameter int             SEL_W   = 2,
  parameter logic [SEL_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= din;
  end
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_load,
  output logic [SEL_W-1:0]  ptr_data,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);
  localparam logic [2:0]       MSB_IDX = 3'(BYTE_W - 1);

  tw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              nack;
  logic              byte_full;

  assign byte_full = (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      nack     <= 1'b0;
      sda_oe   <= 1'b0;
      ptr_load <= 1'b0;
      ptr_data <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      ptr_load <= 1'b0;
      wr_valid <= 1'b0;
      if (bus_start) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          rx <= {rx[BYTE_W-2:0], sda_lvl};
          if (!byte_full) cnt <= cnt + 1'b1;
          if (state == S_RACK) nack <= sda_lvl;
        end
        if (scl_fall) begin
          case (state)
            S_ADDR: if (byte_full) begin
              if (rx[BYTE_W-1:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= rx[0];
                state  <= S_AACK;
              end else begin
                state  <= S_IGN;
              end
            end
            S_AACK: begin
              cnt <= '0;
              if (rw) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_PTR;
              end
            end
            S_PTR: if (byte_full) begin
              ptr_load <= 1'b1;
              ptr_data <= rx[SEL_W-1:0];
              sda_oe   <= 1'b1;
              state    <= S_PACK;
            end
            S_PACK, S_WACK: begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_WR;
            end
            S_WR: if (byte_full) begin
              wr_valid <= 1'b1;
              wr_data  <= rx;
              sda_oe   <= 1'b1;
              state    <= S_WACK;
            end
            S_RD: begin
              if (byte_full) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sda_oe <= ~tx[MSB_IDX - cnt[2:0]];
              end
            end
            S_RACK: begin
              if (nack) begin
                state <= S_IGN;
              end else begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                state  <= S_RD;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R11
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5
  wr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_oe);

  // R4
  ptr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |-> sda_oe);

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_lvl);

  // R3
  ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGN) |-> !sda_oe);

  // R2
  addr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR) |-> !sda_oe);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state == S_ADDR && !sda_oe));
endmodule

// File: rtl/tw_ptr_slave.sv
module tw_ptr_slave
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         SEL_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic ptr_load;
  logic [SEL_W-1:0] ptr_data;
  logic [SEL_W-1:0] ptr_q;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines[g]),
      .q     (sync_lines[g])
    );
  end

  tw_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (sync_lines[0]),
    .sda_s     (sync_lines[1]),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  tw_engine #(.DEV_ADDR(DEV_ADDR), .SEL_W(SEL_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_data   (rd_data_i),
    .ptr_load  (ptr_load),
    .ptr_data  (ptr_data),
    .wr_valid  (wr_valid_o),
    .wr_data   (wr_data_o),
    .sda_oe    (sda_oe_o)
  );

  tw_ptr_reg #(.SEL_W(SEL_W), .RST_VAL('0)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ptr_load),
    .din   (ptr_data),
    .q     (ptr_q)
  );

  assign rd_sel_o = ptr_q;
  assign wr_sel_o = ptr_q;

  // R8
  ptr_hold_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop || bus_start) |=> $stable(rd_sel_o));
endmodule

// File: tb/tw_ptr_slave_tb.sv
module tw_ptr_slave_tb;
  localparam logic [6:0] DEV = 7'h48;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic preset = 1'b1;
  logic sda_oe;
  logic [1:0] rd_sel, wr_sel;
  logic [7:0] rd_data, wr_data;
  logic wr_valid;
  logic sda_line;
  logic [7:0] model [4];

  int checks = 0;
  int fails = 0;
  int wr_count = 0;
  int r10_bad = 0;
  int pw_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic wv_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = !(m_low || sda_oe);
  assign rd_data  = model[rd_sel];

  tw_ptr_slave #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .rd_sel_o(rd_sel), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_sel_o(wr_sel), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (preset) begin
      model[0] <= 8'hA5; model[1] <= 8'h3C; model[2] <= 8'h5A; model[3] <= 8'hC3;
    end else if (wr_valid) begin
      model[wr_sel] <= wr_data;
      wr_count <= wr_count + 1;
    end
  end

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl) r10_bad++;
    if (wr_valid && wv_prev) pw_bad++;
    oe_prev = sda_oe;
    wv_prev = wr_valid;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp=<190000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H);
    m_low = 1'b1; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(H); scl = 1'b1; tick(H); m_low = 1'b0; tick(H);
  endtask

  task automatic send_bit(input bit b);
    m_low = !b; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H/2);
    ack = !sda_line; tick(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); scl = 1'b0;
    end
    m_low = mack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(1); m_low = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a;
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(p, a); bus_stop();
  endtask

  initial begin
    bit a, a2;
    logic [7:0] b1, b2, b3;
    int wc;
    int late_ack;
    tick(3);
    preset = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(4);

    // R8 reset state
    check(rd_sel == 2'd0, "R8 reset pointer", rd_sel, 0);
    check(!sda_oe && !wr_valid, "R8 reset outputs idle", {sda_oe, wr_valid}, 0);

    // R8 read right after reset without pointer
    bus_start(); send_byte({DEV, 1'b1}, a);
    check(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, b1); bus_stop();
    check(b1 == 8'hA5, "R8 read temperature after reset", b1, 8'hA5);

    // R2/R3 address sweep
    wc = wr_count; late_ack = 0;
    for (int ad = 0; ad < 128; ad++) begin
      bus_start(); send_byte({7'(ad), 1'b0}, a);
      check(a == (ad == DEV), "R2 R3 address ack", a, (ad == DEV));
      if (ad != DEV) begin
        send_byte(8'h00, a2); if (a2) late_ack++;
        send_byte(8'h77, a2); if (a2) late_ack++;
      end else begin
        send_byte(8'h00, a2);
      end
      bus_stop();
    end
    check(late_ack == 0, "R3 no ack after mismatch", late_ack, 0);
    check(wr_count == wc, "R3 no write after mismatch", wr_count, wc);

    // R3 read to wrong address: line stays released
    bus_start(); send_byte({DEV ^ 7'h01, 1'b1}, a);
    recv_byte(1'b1, b1); bus_stop();
    check(!a && b1 == 8'hFF, "R3 mismatched read silent", {a, b1}, 8'hFF);

    // R4/R5 write sweep over every pointer, upper pointer bits set
    for (int p = 0; p < 4; p++) begin
      logic [7:0] d;
      d = 8'(p * 53 + 17);
      wc = wr_count;
      bus_start(); send_byte({DEV, 1'b0}, a);
      send_byte(8'hFC | 8'(p), a2);
      check(a2, "R4 pointer byte acked", a2, 1);
      check(rd_sel == 2'(p), "R4 pointer from low bits", rd_sel, p);
      send_byte(d, a2);
      check(a2, "R5 data byte acked", a2, 1);
      bus_stop();
      check(wr_count == wc + 1, "R5 one strobe per byte", wr_count, wc + 1);
      check(model[p] == d, "R5 written value", model[p], d);
    end

    // R5 multi-byte write
    wc = wr_count;
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h02, a);
    send_byte(8'h11, a); send_byte(8'h22, a2); bus_stop();
    check(wr_count == wc + 2, "R5 two strobes", wr_count, wc + 2);
    check(model[2] == 8'h22 && a2, "R5 last byte wins", model[2], 8'h22);

    // R6/R7 read every register, ack then nack, then slave silent
    for (int p = 0; p < 4; p++) begin
      set_ptr(8'(p));
      bus_start(); send_byte({DEV, 1'b1}, a);
      recv_byte(1'b1, b1); recv_byte(1'b0, b2); recv_byte(1'b1, b3); bus_stop();
      check(b1 == model[p], "R6 first read byte", b1, model[p]);
      check(b2 == model[p], "R7 repeat after master ack", b2, model[p]);
      check(b3 == 8'hFF, "R7 silent after nack", b3, 8'hFF);
    end

    // R8 pointer persists across STOP and reads
    bus_start(); send_byte({DEV, 1'b1}, a); recv_byte(1'b0, b1); bus_stop();
    check(b1 == model[3], "R8 pointer persists", b1, model[3]);

    // R9 address-only write leaves pointer
    bus_start(); send_byte({DEV, 1'b0}, a); bus_stop();
    check(rd_sel == 2'd3, "R9 address-only write keeps pointer", rd_sel, 3);

    // R9/R1 pointer then repeated START read
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h01, a);
    bus_start(); send_byte({DEV, 1'b1}, a); recv_byte(1'b0, b1); bus_stop();
    check(b1 == model[1], "R9 combined pointer then read", b1, model[1]);

    // R1 repeated START mid-byte aborts
    wc = wr_count;
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h00, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start(); send_byte({DEV, 1'b1}, a); recv_byte(1'b0, b1); bus_stop();
    check(a && b1 == model[0], "R1 restart mid-byte", b1, model[0]);
    check(wr_count == wc, "R1 aborted byte not written", wr_count, wc);

    tick(10);
    check(r10_bad == 0, "R10 oe rises only with clock low", r10_bad, 0);
    check(pw_bad == 0, "R11 single-cycle strobe", pw_bad, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule